// File: doc/BRIEF.md
# Aging-Counter LRU Tracker

This block keeps the least-recently-used order of the ways in one set of an N-way set-associative cache. Each way owns a small age counter of log2(N) bits and a valid bit. A larger age means the way was used longer ago, and 0 marks the most recently used way. Once the set is full, the ages of its ways are a permutation of 0 to N-1, so the way whose age is N-1 is the one to evict.

Each cycle the surrounding cache controller may present one access event. The event is either a hit on a named way or a miss. On a hit the counters are reordered around the hit way. On a miss the tracker picks the way to fill and ages every other way. The chosen fill way is reported one cycle after the miss, together with a one-cycle strobe. All counters, the valid bits and the current eviction candidate are visible at all times, so a controller can look up the fill way before it sends the miss.

Top module: `lru_age_tracker`

## Requirements
- R1: A synchronous reset, sampled high at a rising edge, clears every age counter, every valid bit, `fill_pulse` and `fill_way`.
- R2: A hit event on a valid way clears that way's age to 0 at the next edge.
- R3: On a hit event on a valid way, every other way whose age was below the hit way's old age has its age raised by 1.
- R4: On a hit event on a valid way, every way whose age was above the hit way's old age keeps its age.
- R5: On a miss while some way is empty, the empty way with the lowest index is filled: its valid bit goes to 1 and its age to 0, and every other way's age rises by 1.
- R6: On a miss with all ways valid, the way with the largest age (which is N-1) is refilled: its age goes to 0 and every other age rises by 1. Valid bits stay at 1.
- R7: In the cycle after a miss event, `fill_pulse` is 1 and `fill_way` holds the way that was filled. After any other cycle `fill_pulse` is 0 and `fill_way` keeps its value.
- R8: With `acc_valid` low, no counter and no valid bit changes.
- R9: A hit event that names a way whose valid bit is 0 is ignored. Counters and valid bits keep their values, and `fill_pulse` stays 0.
- R10: `victim_way` shows the lowest-index empty way while any way is empty. When the set is full, it shows the way whose age is N-1.
- R11: For 4 ways, starting from reset, the event sequence miss, miss, hit way 0, miss, miss, hit way 1, miss, miss leaves ages (way 0..3) of 0111, 1022, 0122, 1203, 2310, 3021, 0132, 1203 after each event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| acc_valid | input | 1 | An access event is present this cycle |
| acc_hit | input | 1 | 1 = hit on `acc_way`, 0 = miss |
| acc_way | input | WAYW | Way index of a hit event |
| fill_pulse | output | 1 | One-cycle strobe after a miss |
| fill_way | output | WAYW | Way filled by the last miss |
| victim_way | output | WAYW | Way a miss would fill now |
| age_flat | output | NUM_WAYS*WAYW | Age of way i at bits [i*WAYW +: WAYW] |
| way_valid | output | NUM_WAYS | Valid bit per way, bit i for way i |

WAYW is log2(NUM_WAYS).

## Verification
The bench builds the tracker with NUM_WAYS = 4, so each age counter is 2 bits wide. With this size the set fills after four misses. That puts the full-set refill path, the permutation of ages and the hand-worked 4-way event trace within a handful of cycles. The small way count also lets a few hundred random events visit every ordering of ages many times, including hits on empty ways between resets.

// File: rtl/lru_age_pkg.sv
package lru_age_pkg;

   // decoded access event after the empty-way filter
   typedef enum logic [1:0] {
      EVT_IDLE = 2'd0,
      EVT_HIT  = 2'd1,
      EVT_MISS = 2'd2
   } lru_evt_e;

   function automatic int unsigned way_idx_bits(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/lru_age_cell.sv
module lru_age_cell #(
   parameter int unsigned AGE_W = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             upd_en,
   input  logic             is_target,
   input  logic             bump_all,
   input  logic [AGE_W-1:0] ref_age,
   input  logic             set_valid,
   output logic [AGE_W-1:0] age_q,
   output logic             valid_q
);

   logic [AGE_W-1:0] age_d;
   logic             valid_d;

   always_comb begin
      age_d   = age_q;
      valid_d = valid_q;
      if (upd_en) begin
         if (is_target) begin
            age_d = '0;
            if (set_valid) valid_d = 1'b1;
         end else if (bump_all || (age_q < ref_age)) begin
            age_d = age_q + AGE_W'(1);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         age_q   <= '0;
         valid_q <= 1'b0;
      end else begin
         age_q   <= age_d;
         valid_q <= valid_d;
      end
   end

endmodule

// File: rtl/lru_age_victim.sv
module lru_age_victim #(
   parameter int unsigned NUM_WAYS = 4,
   parameter int unsigned AGE_W    = 2
) (
   input  logic [NUM_WAYS*AGE_W-1:0] ages,
   input  logic [NUM_WAYS-1:0]       valids,
   output logic [AGE_W-1:0]          victim
);

   generate
      if (NUM_WAYS == 2) begin : g_pair
         always_comb begin
            if (!valids[0])      victim = AGE_W'(0);
            else if (!valids[1]) victim = AGE_W'(1);
            else                 victim = (ages[AGE_W +: AGE_W] > ages[0 +: AGE_W])
                                          ? AGE_W'(1) : AGE_W'(0);
         end
      end else begin : g_scan
         logic [AGE_W-1:0] first_empty;
         logic             any_empty;
         logic [AGE_W-1:0] oldest;
         logic [AGE_W-1:0] oldest_age;

         always_comb begin
            first_empty = '0;
            any_empty   = 1'b0;
            for (int i = NUM_WAYS - 1; i >= 0; i--) begin
               if (!valids[i]) begin
                  first_empty = AGE_W'(i);
                  any_empty   = 1'b1;
               end
            end
         end

         always_comb begin
            oldest     = '0;
            oldest_age = ages[0 +: AGE_W];
            for (int i = 1; i < NUM_WAYS; i++) begin
               if (ages[i*AGE_W +: AGE_W] > oldest_age) begin
                  oldest     = AGE_W'(i);
                  oldest_age = ages[i*AGE_W +: AGE_W];
               end
            end
         end

         assign victim = any_empty ? first_empty : oldest;
      end
   endgenerate

endmodule

// File: rtl/lru_age_tracker.sv
module lru_age_tracker
   import lru_age_pkg::*;
#(
   parameter int unsigned NUM_WAYS = 4,
   localparam int unsigned WAYW    = way_idx_bits(NUM_WAYS)
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     acc_valid,
   input  logic                     acc_hit,
   input  logic [WAYW-1:0]          acc_way,
   output logic                     fill_pulse,
   output logic [WAYW-1:0]          fill_way,
   output logic [WAYW-1:0]          victim_way,
   output logic [NUM_WAYS*WAYW-1:0] age_flat,
   output logic [NUM_WAYS-1:0]      way_valid
);

   generate
      if (NUM_WAYS < 2 || (NUM_WAYS & (NUM_WAYS - 1)) != 0) begin : g_bad_ways
         $error("lru_age_tracker: NUM_WAYS must be a power of two of at least 2");
      end
   endgenerate

   lru_evt_e        evt;
   logic [WAYW-1:0] target;
   logic [WAYW-1:0] ref_age;
   logic            hit_on_valid;

   assign hit_on_valid = way_valid[acc_way];

   always_comb begin
      if (!acc_valid)        evt = EVT_IDLE;
      else if (!acc_hit)     evt = EVT_MISS;
      else if (hit_on_valid) evt = EVT_HIT;
      else                   evt = EVT_IDLE;
   end

   assign target  = (evt == EVT_MISS) ? victim_way : acc_way;
   assign ref_age = age_flat[acc_way*WAYW +: WAYW];

   lru_age_victim #(
      .NUM_WAYS (NUM_WAYS),
      .AGE_W    (WAYW)
   ) victim_i (
      .ages   (age_flat),
      .valids (way_valid),
      .victim (victim_way)
   );

   generate
      for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
         lru_age_cell #(
            .AGE_W (WAYW)
         ) cell_i (
            .clk       (clk),
            .rst       (rst),
            .upd_en    (evt != EVT_IDLE),
            .is_target (target == WAYW'(w)),
            .bump_all  (evt == EVT_MISS),
            .ref_age   (ref_age),
            .set_valid (evt == EVT_MISS),
            .age_q     (age_flat[w*WAYW +: WAYW]),
            .valid_q   (way_valid[w])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         fill_pulse <= 1'b0;
         fill_way   <= '0;
      end else begin
         fill_pulse <= (evt == EVT_MISS);
         if (evt == EVT_MISS) fill_way <= victim_way;
      end
   end

endmodule

// File: rtl/lru_age_tracker_chk.sv
module lru_age_tracker_chk #(
   parameter int unsigned NUM_WAYS = 4,
   parameter int unsigned WAYW     = 2
) (
   input logic                     clk,
   input logic                     rst,
   input logic                     acc_valid,
   input logic                     acc_hit,
   input logic [WAYW-1:0]          acc_way,
   input logic                     fill_pulse,
   input logic [WAYW-1:0]          fill_way,
   input logic [WAYW-1:0]          victim_way,
   input logic [NUM_WAYS*WAYW-1:0] age_flat,
   input logic [NUM_WAYS-1:0]      way_valid
);

   // R2
   hit_clears_chk: assert property (@(posedge clk) disable iff (rst)
      (acc_valid && acc_hit && way_valid[acc_way])
      |=> (age_flat[$past(acc_way)*WAYW +: WAYW] == '0));

   // R7
   miss_strobe_chk: assert property (@(posedge clk) disable iff (rst)
      (acc_valid && !acc_hit) |=> (fill_pulse && way_valid[fill_way]));

   // R7
   strobe_cause_chk: assert property (@(posedge clk) disable iff (rst)
      !(acc_valid && !acc_hit) |=> !fill_pulse);

   // R8
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !acc_valid |=> ($stable(age_flat) && $stable(way_valid)));

   // R9
   empty_hit_chk: assert property (@(posedge clk) disable iff (rst)
      (acc_valid && acc_hit && !way_valid[acc_way])
      |=> ($stable(age_flat) && $stable(way_valid)));

   // R10
   victim_empty_chk: assert property (@(posedge clk) disable iff (rst)
      !(&way_valid) |-> !way_valid[victim_way]);

   // R6
   full_oldest_chk: assert property (@(posedge clk) disable iff (rst)
      (&way_valid) |-> (age_flat[victim_way*WAYW +: WAYW] == WAYW'(NUM_WAYS - 1)));

endmodule

bind lru_age_tracker lru_age_tracker_chk #(
   .NUM_WAYS (NUM_WAYS),
   .WAYW     (WAYW)
) chk_i (
   .clk        (clk),
   .rst        (rst),
   .acc_valid  (acc_valid),
   .acc_hit    (acc_hit),
   .acc_way    (acc_way),
   .fill_pulse (fill_pulse),
   .fill_way   (fill_way),
   .victim_way (victim_way),
   .age_flat   (age_flat),
   .way_valid  (way_valid)
);

// File: tb/lru_age_tracker_tb_top.sv
module lru_age_tracker_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int N = 4;
   localparam int W = 2;

   logic           clk = 1'b0;
   logic           rst = 1'b1;
   logic           acc_valid = 1'b0;
   logic           acc_hit = 1'b0;
   logic [W-1:0]   acc_way = '0;
   logic           fill_pulse;
   logic [W-1:0]   fill_way;
   logic [W-1:0]   victim_way;
   logic [N*W-1:0] age_flat;
   logic [N-1:0]   way_valid;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lru_age_tracker #(.NUM_WAYS(N)) dut_i (
      .clk        (clk),
      .rst        (rst),
      .acc_valid  (acc_valid),
      .acc_hit    (acc_hit),
      .acc_way    (acc_way),
      .fill_pulse (fill_pulse),
      .fill_way   (fill_way),
      .victim_way (victim_way),
      .age_flat   (age_flat),
      .way_valid  (way_valid)
   );

   typedef struct {
      logic [N*W-1:0] age;
      logic [N-1:0]   val;
      logic           pulse;
      logic [W-1:0]   fill;
      logic [W-1:0]   vic;
      int             req;
   } exp_t;

   exp_t sb_q[$];

   // reference state built from the requirements
   int m_age[N];
   bit m_val[N];
   bit m_pulse;
   int m_fill;

   function automatic int model_victim();
      int best;
      for (int i = 0; i < N; i++) if (!m_val[i]) return i;
      best = 0;
      for (int i = 1; i < N; i++) if (m_age[i] > m_age[best]) best = i;
      return best;
   endfunction

   function automatic void model_reset();
      for (int i = 0; i < N; i++) begin
         m_age[i] = 0;
         m_val[i] = 0;
      end
      m_pulse = 0;
      m_fill  = 0;
   endfunction

   function automatic void model_event(bit v, bit h, int way);
      int old;
      int vic;
      m_pulse = 0;
      if (!v) return;
      if (h) begin
         if (!m_val[way]) return;
         old = m_age[way];
         for (int i = 0; i < N; i++) begin
            if (i == way) m_age[i] = 0;
            else if (m_age[i] < old) m_age[i]++;
         end
      end else begin
         vic = model_victim();
         for (int i = 0; i < N; i++) begin
            if (i == vic) m_age[i] = 0;
            else m_age[i]++;
         end
         m_val[vic] = 1;
         m_pulse = 1;
         m_fill = vic;
      end
   endfunction

   function automatic exp_t snap(int req);
      exp_t e;
      for (int i = 0; i < N; i++) begin
         e.age[i*W +: W] = W'(m_age[i]);
         e.val[i] = m_val[i];
      end
      e.pulse = m_pulse;
      e.fill  = W'(m_fill);
      e.vic   = W'(model_victim());
      e.req   = req;
      return e;
   endfunction

   // driver: one event per call, expectation queued for the monitor
   task automatic drive(bit v, bit h, int way, int req);
      @(negedge clk);
      acc_valid = v;
      acc_hit   = h;
      acc_way   = W'(way);
      model_event(v, h, way);
      sb_q.push_back(snap(req));
      @(posedge clk);
      #1;
      acc_valid = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      model_reset();
      sb_q.push_back(snap(1)); // R1
      @(posedge clk);
      #1;
      rst = 1'b0;
   endtask

   // monitor: compare right after each edge that has an expectation
   initial begin
      exp_t e;
      forever begin
         @(posedge clk);
         #1;
         if (sb_q.size() > 0) begin
            e = sb_q.pop_front();
            checks++;
            if (age_flat !== e.age || way_valid !== e.val || fill_pulse !== e.pulse ||
                fill_way !== e.fill || victim_way !== e.vic) begin
               errors++;
               $display("FAIL R%0d: age=%h valid=%b pulse=%b fill=%0d victim=%0d expected age=%h valid=%b pulse=%b fill=%0d victim=%0d",
                        e.req, age_flat, way_valid, fill_pulse, fill_way, victim_way,
                        e.age, e.val, e.pulse, e.fill, e.vic);
            end
         end
      end
   end

   task automatic trace_chk(int a0, int a1, int a2, int a3);
      logic [N*W-1:0] want;
      want = {W'(a3), W'(a2), W'(a1), W'(a0)};
      #1;
      checks++;
      if (age_flat !== want) begin
         errors++;
         $display("FAIL R11: age=%h expected %h", age_flat, want);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog R7: actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      model_reset();
      repeat (2) @(posedge clk);
      do_reset();                             // R1

      // R11 trace, also R5, R2, R3, R4, R6, R7
      drive(1, 0, 0, 5); trace_chk(0, 1, 1, 1);
      drive(1, 0, 0, 5); trace_chk(1, 0, 2, 2);
      drive(1, 1, 0, 3); trace_chk(0, 1, 2, 2);
      drive(1, 0, 0, 5); trace_chk(1, 2, 0, 3);
      drive(1, 0, 0, 5); trace_chk(2, 3, 1, 0);
      drive(1, 1, 1, 4); trace_chk(3, 0, 2, 1);
      drive(1, 0, 0, 6); trace_chk(0, 1, 3, 2);
      drive(1, 0, 0, 6); trace_chk(1, 2, 0, 3);

      drive(0, 0, 2, 8);                      // R8 idle
      drive(0, 1, 3, 8);                      // R8 idle with stale fields
      drive(1, 1, 3, 4);                      // R4 hit on oldest: all below rise
      drive(1, 1, 3, 2);                      // R2 hit on MRU: nothing moves
      drive(1, 1, 0, 3);                      // R3
      drive(1, 0, 0, 6);                      // R6 full miss
      drive(1, 0, 0, 7);                      // R7 back-to-back miss

      do_reset();                             // R1
      drive(1, 1, 2, 9);                      // R9 hit on empty way
      drive(1, 0, 0, 10);                     // R10 lowest empty filled
      drive(1, 1, 3, 9);                      // R9
      drive(1, 0, 0, 5);                      // R5
      drive(1, 1, 0, 3);                      // R3 with empty ways present
      drive(1, 1, 2, 9);                      // R9
      drive(1, 0, 0, 10);                     // R10

      for (int n = 0; n < 400; n++) begin
         if (n % 97 == 96) do_reset();        // R1
         else drive($urandom_range(0, 7) != 0, $urandom_range(0, 2) != 0,
                    int'($urandom_range(0, N - 1)), 10); // R10 random mix
      end

      repeat (3) @(posedge clk);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule